// File: doc/BRIEF.md
# Cascadable Timer Pair

This block holds two 32-bit up-counting timers that share one clock and one register port. Timer 0 is the lower instance and timer 1 the upper. Each timer has these parts:
- a clock prescaler;
- a load value used for automatic reload;
- a compare value;
- a sticky overflow interrupt flag;
- a waveform output that changes on overflow and compare events.

When its cascade bit is set, timer 1 no longer counts its own prescaled ticks. Instead it advances once for every rising edge of timer 0's waveform output. Timer 0 then acts as a programmable 32-bit prescaler in front of timer 1, and the pair forms a counter of up to 64 bits.

Software reads the pair through two 32-bit reads. Reading timer 0's count also copies timer 1's count into a snapshot register, so the two halves come from the same clock edge. All outputs are registered.

Top module: `cascade_timer_pair`

## Requirements
- R1: After a synchronous active-high reset, every control, load, compare, count, snapshot and flag register reads 0. The read data, both interrupt outputs and both waveform outputs are low.
- R2: The register port uses this word map:
  - per timer `i` at base `4*i`: +0 control, +1 load, +2 compare, +3 count;
  - 8: snapshot;
  - 9: interrupt flags, where bit 0 is timer 0 and bit 1 is timer 1.

  Read data appears on `reg_rdata` one clock after `reg_rd` and holds until the next read. Control reads return the control bits zero-extended.
- R3: A timer's tick occurs only while its run bit (control bit 0) is set. On each tick the count rises by exactly one. A write to the count register loads the written value, and that write takes priority over a tick in the same cycle.
- R4: The prescaler is set by control bit 4 (enable) and bits 7:5 (exponent `e`). When the enable is clear, the timer ticks on every clock. When it is set, the timer ticks once every 2^(e+1) clocks. Writing the control register restarts the prescaler phase.
- R5: A tick at count 0xFFFFFFFF is an overflow. With auto-reload set (control bit 1), the count takes the load value. Otherwise the count becomes 0 and hardware clears the run bit, unless the control register is written in the same cycle.
- R6: Toggle mode (control bit 2 = 0): the waveform output inverts on each overflow tick. When compare enable (control bit 3) is set, it also inverts on each non-overflow tick whose count before the tick equals the compare value.
- R7: Pulse mode (control bit 2 = 1): the waveform output is high for exactly one tick period after each overflow tick and low after every other tick.
- R8: Timer 1's control bit 8 (cascade) makes timer 1 tick once per rising edge of timer 0's waveform output, and its own prescaler is then ignored. Timer 1 therefore advances at most one per clock. Control bit 8 of timer 0 always reads 0.
- R9: An overflow sets that timer's flag, which drives its interrupt output. The flag stays set until a 1 is written to its bit at address 9. If an overflow and a clear arrive in the same cycle, the flag ends up set. In cascade mode, overflow of the combined 64-bit count appears only on timer 1's flag.
- R10: A read of timer 0's count captures timer 1's count into the snapshot register, at the same edge that timer 0's count is returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Word address |
| reg_wdata | input | CNT_W | Write data |
| reg_rdata | output | CNT_W | Registered read data |
| irq_lo | output | 1 | Timer 0 overflow flag |
| irq_hi | output | 1 | Timer 1 overflow flag |
| pwm_lo | output | 1 | Timer 0 waveform output |
| pwm_hi | output | 1 | Timer 1 waveform output |

## Verification
A tick that is visible in one cycle changes the count, the waveform output and the flag at the next rising edge. A register write takes effect at the edge that samples it. Read data is due one edge after the read strobe. In cascade mode, a rise of timer 0's output advances timer 1 one edge later, because the rise is seen through one register stage.

The bench advances a behavioural model at each rising edge from the inputs driven at the previous falling edge. It compares all five outputs at the following falling edge, so every result is checked in exactly the cycle the timing above calls for.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int PS_EXP_W = 3;

  typedef struct packed {
    logic                casc;
    logic [PS_EXP_W-1:0] ps_exp;
    logic                ps_en;
    logic                cmp_en;
    logic                pulse;
    logic                reload;
    logic                run;
  } tmr_ctrl_t;

  localparam int CTRL_W   = $bits(tmr_ctrl_t);
  localparam int N_TMR    = 2;
  localparam int OFS_CTRL = 0;
  localparam int OFS_LOAD = 1;
  localparam int OFS_CMP  = 2;
  localparam int OFS_CNT  = 3;
  localparam int STRIDE   = 4;
  localparam int A_SNAP   = 8;
  localparam int A_IRQ    = 9;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int EXP_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             clr,
  input  logic             ps_en,
  input  logic [EXP_W-1:0] ps_exp,
  output logic             tick
);
  localparam int DIV_W = 2 ** EXP_W;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] limit;
  logic [EXP_W-1:0] sh;

  assign sh    = EXP_W'(DIV_W - 1) - ps_exp;
  assign limit = {DIV_W{1'b1}} >> sh;
  assign tick  = en & (~ps_en | (div_q == limit));

  always_ff @(posedge clk) begin
    if (rst || clr || !en || !ps_en) div_q <= '0;
    else if (div_q == limit)         div_q <= '0;
    else                             div_q <= div_q + DIV_W'(1);
  end

  // divided ticks are never back to back while the setting is unchanged
  assert_tick_gap_R4: assert property (@(posedge clk) disable iff (rst)
    (tick && ps_en && !clr) |=> !tick);
endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             wr_cnt,
  input  logic [CNT_W-1:0] wr_val,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] cmp_val,
  input  logic             reload,
  input  logic             pulse,
  input  logic             cmp_en,
  output logic [CNT_W-1:0] cnt,
  output logic             pwm,
  output logic             ovf
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic eff, at_max, cmp_hit;

  assign eff     = tick & ~wr_cnt;
  assign at_max  = (cnt == CNT_MAX);
  assign ovf     = eff & at_max;
  assign cmp_hit = cmp_en & ~at_max & (cnt == cmp_val);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      pwm <= 1'b0;
    end else begin
      if (wr_cnt)      cnt <= wr_val;
      else if (tick)   cnt <= at_max ? (reload ? load_val : '0) : cnt + CNT_W'(1);
      if (eff) begin
        if (pulse)                  pwm <= at_max;
        else if (at_max || cmp_hit) pwm <= ~pwm;
      end
    end
  end

  assert_step_R3: assert property (@(posedge clk) disable iff (rst)
    (tick && !wr_cnt && !at_max) |=> (cnt == $past(cnt) + CNT_W'(1)));
  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!tick && !wr_cnt) |=> ($stable(cnt) && $stable(pwm)));
  assert_wrap_R5: assert property (@(posedge clk) disable iff (rst)
    (tick && !wr_cnt && at_max) |=> (cnt == ($past(reload) ? $past(load_val) : '0)));
  assert_pulse_low_R7: assert property (@(posedge clk) disable iff (rst)
    (pulse && tick && !wr_cnt && !at_max) |=> !pwm);
endmodule

// File: rtl/cascade_timer_pair.sv
module cascade_timer_pair
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [CNT_W-1:0]  reg_wdata,
  output logic [CNT_W-1:0]  reg_rdata,
  output logic              irq_lo,
  output logic              irq_hi,
  output logic              pwm_lo,
  output logic              pwm_hi
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  tmr_ctrl_t         ctrl_q [N_TMR];
  logic [CNT_W-1:0]  load_q [N_TMR];
  logic [CNT_W-1:0]  cmp_q  [N_TMR];
  logic [CNT_W-1:0]  cnt    [N_TMR];
  logic [CNT_W-1:0]  shadow_q, rdata_q, rd_mux;
  logic [N_TMR-1:0]  flag_q, tick, ovf, pwm, ps_tick;
  logic [N_TMR-1:0]  wr_ctrl, wr_load, wr_cmp, wr_cnt, irq_clr;
  logic              pwm0_q, lo_rise, wr_irq, rd_lo_cnt;

  assign lo_rise   = pwm[0] & ~pwm0_q;
  assign wr_irq    = reg_wr && (reg_addr == ADDR_W'(A_IRQ));
  assign irq_clr   = wr_irq ? reg_wdata[N_TMR-1:0] : '0;
  assign rd_lo_cnt = reg_rd && (reg_addr == ADDR_W'(OFS_CNT));

  for (genvar i = 0; i < N_TMR; i++) begin : g_tmr
    assign wr_ctrl[i] = reg_wr && (reg_addr == ADDR_W'(STRIDE*i + OFS_CTRL));
    assign wr_load[i] = reg_wr && (reg_addr == ADDR_W'(STRIDE*i + OFS_LOAD));
    assign wr_cmp[i]  = reg_wr && (reg_addr == ADDR_W'(STRIDE*i + OFS_CMP));
    assign wr_cnt[i]  = reg_wr && (reg_addr == ADDR_W'(STRIDE*i + OFS_CNT));

    tmr_prescaler #(.EXP_W(PS_EXP_W)) u_ps (
      .clk    (clk),
      .rst    (rst),
      .en     (ctrl_q[i].run),
      .clr    (wr_ctrl[i]),
      .ps_en  (ctrl_q[i].ps_en),
      .ps_exp (ctrl_q[i].ps_exp),
      .tick   (ps_tick[i])
    );

    if (i == 0) begin : g_src
      assign tick[i] = ctrl_q[i].run & ps_tick[i];
    end else begin : g_src
      assign tick[i] = ctrl_q[i].run & (ctrl_q[i].casc ? lo_rise : ps_tick[i]);
    end

    tmr_core #(.CNT_W(CNT_W)) u_core (
      .clk      (clk),
      .rst      (rst),
      .tick     (tick[i]),
      .wr_cnt   (wr_cnt[i]),
      .wr_val   (reg_wdata),
      .load_val (load_q[i]),
      .cmp_val  (cmp_q[i]),
      .reload   (ctrl_q[i].reload),
      .pulse    (ctrl_q[i].pulse),
      .cmp_en   (ctrl_q[i].cmp_en),
      .cnt      (cnt[i]),
      .pwm      (pwm[i]),
      .ovf      (ovf[i])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < N_TMR; i++) begin
      if (reg_addr == ADDR_W'(STRIDE*i + OFS_CTRL)) rd_mux = CNT_W'(ctrl_q[i]);
      if (reg_addr == ADDR_W'(STRIDE*i + OFS_LOAD)) rd_mux = load_q[i];
      if (reg_addr == ADDR_W'(STRIDE*i + OFS_CMP))  rd_mux = cmp_q[i];
      if (reg_addr == ADDR_W'(STRIDE*i + OFS_CNT))  rd_mux = cnt[i];
    end
    if (reg_addr == ADDR_W'(A_SNAP)) rd_mux = shadow_q;
    if (reg_addr == ADDR_W'(A_IRQ))  rd_mux = CNT_W'(flag_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N_TMR; i++) begin
        ctrl_q[i] <= '0;
        load_q[i] <= '0;
        cmp_q[i]  <= '0;
      end
      flag_q   <= '0;
      shadow_q <= '0;
      rdata_q  <= '0;
      pwm0_q   <= 1'b0;
    end else begin
      for (int i = 0; i < N_TMR; i++) begin
        if (wr_ctrl[i]) begin
          ctrl_q[i] <= tmr_ctrl_t'(reg_wdata[CTRL_W-1:0]);
          if (i == 0) ctrl_q[i].casc <= 1'b0;
        end else if (ovf[i] && !ctrl_q[i].reload) begin
          ctrl_q[i].run <= 1'b0;
        end
        if (wr_load[i]) load_q[i] <= reg_wdata;
        if (wr_cmp[i])  cmp_q[i]  <= reg_wdata;
      end
      flag_q <= (flag_q & ~irq_clr) | ovf;
      pwm0_q <= pwm[0];
      if (reg_rd)    rdata_q  <= rd_mux;
      if (rd_lo_cnt) shadow_q <= cnt[1];
    end
  end

  assign reg_rdata = rdata_q;
  assign irq_lo    = flag_q[0];
  assign irq_hi    = flag_q[1];
  assign pwm_lo    = pwm[0];
  assign pwm_hi    = pwm[1];

  assert_read_lat_R2: assert property (@(posedge clk) disable iff (rst)
    rd_lo_cnt |=> (reg_rdata == $past(cnt[0])));
  assert_snap_R10: assert property (@(posedge clk) disable iff (rst)
    rd_lo_cnt |=> (shadow_q == $past(cnt[1])));
  assert_casc_idle_R8: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q[1].casc && !lo_rise && !wr_cnt[1]) |=> $stable(cnt[1]));
  assert_casc_step_R8: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q[1].casc && !wr_cnt[1] && cnt[1] != CNT_MAX) |=> ((cnt[1] - $past(cnt[1])) <= CNT_W'(1)));
  assert_flag_sticky_lo_R9: assert property (@(posedge clk) disable iff (rst)
    (irq_lo && !irq_clr[0]) |=> irq_lo);
  assert_flag_sticky_hi_R9: assert property (@(posedge clk) disable iff (rst)
    (irq_hi && !irq_clr[1]) |=> irq_hi);
  assert_lo_no_casc_R8: assert property (@(posedge clk) disable iff (rst)
    !ctrl_q[0].casc);
endmodule

// File: tb/cascade_timer_pair_tb.sv
module cascade_timer_pair_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_lo, irq_hi, pwm_lo, pwm_hi;

  int n_chk = 0, n_fail = 0, cyc = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  cascade_timer_pair u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_lo(irq_lo), .irq_hi(irq_hi),
    .pwm_lo(pwm_lo), .pwm_hi(pwm_hi)
  );

  // behavioural reference state; ctrl bits: 0 run, 1 reload, 2 pulse, 3 cmp_en, 4 ps_en, 7:5 exp, 8 cascade
  logic [8:0]  m_ctrl [2];
  logic [31:0] m_load [2], m_cmp [2], m_cnt [2];
  int          m_div  [2];
  logic        m_pwm  [2];
  logic        m_pq;
  logic [1:0]  m_flag;
  logic [31:0] m_shadow, m_rdata;
  // next-state temporaries
  logic [8:0]  n_ctrl [2];
  logic [31:0] n_load [2], n_cmp [2], n_cnt [2];
  int          n_div  [2];
  logic        n_pwm  [2];
  logic        tk [2], ov [2];
  logic        src, wrc, wrctl, ch;
  int          lim;

  function automatic logic [31:0] mdl_read(input logic [3:0] a);
    case (a)
      4'd0: return {23'd0, m_ctrl[0]};
      4'd1: return m_load[0];
      4'd2: return m_cmp[0];
      4'd3: return m_cnt[0];
      4'd4: return {23'd0, m_ctrl[1]};
      4'd5: return m_load[1];
      4'd6: return m_cmp[1];
      4'd7: return m_cnt[1];
      4'd8: return m_shadow;
      4'd9: return {30'd0, m_flag};
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 2; i++) begin
        m_ctrl[i] = '0; m_load[i] = '0; m_cmp[i] = '0; m_cnt[i] = '0;
        m_div[i] = 0; m_pwm[i] = 1'b0;
      end
      m_pq = 1'b0; m_flag = '0; m_shadow = '0; m_rdata = '0;
    end else begin
      for (int i = 0; i < 2; i++) begin
        lim   = (1 << (int'(m_ctrl[i][7:5]) + 1)) - 1;
        if (i == 1 && m_ctrl[1][8]) src = m_pwm[0] && !m_pq;
        else                        src = !m_ctrl[i][4] || (m_div[i] == lim);
        wrc   = reg_wr && (reg_addr == 4'(4*i + 3));
        wrctl = reg_wr && (reg_addr == 4'(4*i));
        tk[i] = m_ctrl[i][0] && src && !wrc;
        ov[i] = tk[i] && (m_cnt[i] == 32'hFFFF_FFFF);
        ch    = tk[i] && !ov[i] && m_ctrl[i][3] && (m_cnt[i] == m_cmp[i]);
        if (wrc)        n_cnt[i] = reg_wdata;
        else if (ov[i]) n_cnt[i] = m_ctrl[i][1] ? m_load[i] : 32'd0;
        else if (tk[i]) n_cnt[i] = m_cnt[i] + 32'd1;
        else            n_cnt[i] = m_cnt[i];
        if (!tk[i])            n_pwm[i] = m_pwm[i];
        else if (m_ctrl[i][2]) n_pwm[i] = ov[i];
        else if (ov[i] || ch)  n_pwm[i] = !m_pwm[i];
        else                   n_pwm[i] = m_pwm[i];
        if (wrctl || !m_ctrl[i][0] || !m_ctrl[i][4] || m_div[i] == lim) n_div[i] = 0;
        else n_div[i] = m_div[i] + 1;
        if (wrctl)                      n_ctrl[i] = reg_wdata[8:0] & ((i == 0) ? 9'h0FF : 9'h1FF);
        else if (ov[i] && !m_ctrl[i][1]) n_ctrl[i] = m_ctrl[i] & 9'h1FE;
        else                            n_ctrl[i] = m_ctrl[i];
        n_load[i] = (reg_wr && reg_addr == 4'(4*i + 1)) ? reg_wdata : m_load[i];
        n_cmp[i]  = (reg_wr && reg_addr == 4'(4*i + 2)) ? reg_wdata : m_cmp[i];
      end
      if (reg_rd) m_rdata = mdl_read(reg_addr);
      if (reg_rd && reg_addr == 4'd3) m_shadow = m_cnt[1];
      m_flag = (m_flag & ~((reg_wr && reg_addr == 4'd9) ? reg_wdata[1:0] : 2'b00)) | {ov[1], ov[0]};
      m_pq = m_pwm[0];
      for (int i = 0; i < 2; i++) begin
        m_ctrl[i] = n_ctrl[i]; m_load[i] = n_load[i]; m_cmp[i] = n_cmp[i];
        m_cnt[i] = n_cnt[i]; m_div[i] = n_div[i]; m_pwm[i] = n_pwm[i];
      end
    end
  end

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual %h expected %h at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  // compare every output against the reference at each falling edge
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      check({31'd0, pwm_lo}, {31'd0, m_pwm[0]}, cur_req, "pwm_lo");
      check({31'd0, pwm_hi}, {31'd0, m_pwm[1]}, cur_req, "pwm_hi");
      check({31'd0, irq_lo}, {31'd0, m_flag[0]}, cur_req, "irq_lo");
      check({31'd0, irq_hi}, {31'd0, m_flag[1]}, cur_req, "irq_hi");
      check(reg_rdata, m_rdata, cur_req, "rdata");
    end
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL watchdog expired actual %0d expected below 100000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state at the ports and in the registers
    check({28'd0, pwm_lo, pwm_hi, irq_lo, irq_hi}, 32'd0, "R1", "outputs after reset");
    for (int a = 0; a < 10; a++) begin
      rd(4'(a));
      check(reg_rdata, 32'd0, "R1", "register after reset");
    end

    // R2 R3 R6: toggle mode with compare, auto-reload, no prescaler
    cur_req = "R6";
    wr(4'd1, 32'hFFFF_FFE8);
    wr(4'd2, 32'hFFFF_FFF6);
    wr(4'd3, 32'hFFFF_FFF0);
    wr(4'd0, 32'h0000_000B);
    for (int k = 0; k < 12; k++) begin
      rd(4'd3);
      idle(4);
    end
    cur_req = "R2";
    rd(4'd0); rd(4'd1); rd(4'd2);

    // R9: clear the sticky flag; then clear coinciding with further overflows
    cur_req = "R9";
    wr(4'd9, 32'd1);
    idle(3);
    for (int k = 0; k < 30; k++) wr(4'd9, 32'd1);
    rd(4'd9);

    // R4 R7: pulse mode, prescaler divide by 4, control write restarts phase
    cur_req = "R7";
    wr(4'd3, 32'hFFFF_FFF8);
    wr(4'd0, 32'h0000_0037);
    idle(90);
    cur_req = "R4";
    wr(4'd0, 32'h0000_00F7);
    idle(5);
    wr(4'd0, 32'h0000_0037);
    idle(40);
    rd(4'd3);

    // R5: timer 1 alone, divide by 2, no auto-reload: stops and clears run
    cur_req = "R5";
    wr(4'd7, 32'hFFFF_FFF4);
    wr(4'd4, 32'h0000_0011);
    idle(40);
    rd(4'd4);
    rd(4'd7);
    wr(4'd9, 32'd3);
    idle(2);

    // R8 R9: cascade, timer 0 pulses every 4 clocks, timer 1 wraps 64-bit and stops
    cur_req = "R8";
    wr(4'd1, 32'hFFFF_FFFC);
    wr(4'd3, 32'hFFFF_FFFC);
    wr(4'd0, 32'h0000_0007);
    wr(4'd7, 32'hFFFF_FFFD);
    wr(4'd4, 32'h0000_0111);
    idle(60);
    rd(4'd4);
    wr(4'd0, 32'h0000_0107);
    rd(4'd0);

    // R10: snapshot reads while timer 1 counts in cascade with toggle source
    cur_req = "R10";
    wr(4'd1, 32'hFFFF_FFF0);
    wr(4'd2, 32'hFFFF_FFF8);
    wr(4'd0, 32'h0000_000B);
    wr(4'd5, 32'd0);
    wr(4'd7, 32'd0);
    wr(4'd4, 32'h0000_0103);
    for (int k = 0; k < 25; k++) begin
      rd(4'd3);
      rd(4'd8);
      idle(7);
    end

    cur_req = "R3";
    wr(4'd4, 32'h0000_0001);
    for (int k = 0; k < 6; k++) rd(4'd7);
    idle(4);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule